// File: doc/BRIEF.md
# Exception Level and Security State Tracker

This block keeps a processor core's current privilege level, from EL0 up to EL3, together with the secure or non-secure state that applies to the lower levels. The level changes in two ways. An exception entry names a target level and may only raise the level or keep it the same. An exception return names a target level and may only lower the level or keep it the same. A request that points the wrong way is refused, and a fault flag reports the refusal.

The security state comes from a single bit in a configuration register. Only code running at EL3 may write that register. A write attempted from any lower level is discarded and reported as a fault. The block drives the current level in three forms: a 2-bit code, a 64-bit read-only register view, and a Secure/Non-secure indication for the level now in use.

All outputs are registered. A request presented in one clock cycle shows up on the outputs in the next cycle.

Top module: `el_sec_tracker`

## Requirements
- R1: Synchronous reset (rst=1) sets the level to HIGHEST_EL (default 3), clears the non-secure bit, drives `is_secure`=1 and `illegal`=0, and sets the register view to the reset level in bits [3:2].
- R2: A take request (`take_req`=1) whose target `take_lvl` is greater than or equal to the current level sets `cur_el` to that target on the next cycle, and `illegal` stays 0.
- R3: A take request whose target is lower than the current level leaves the level unchanged. `illegal` is 1 for exactly the following cycle.
- R4: A return request (`ret_req`=1) whose target `ret_lvl` is lower than or equal to the current level sets `cur_el` to that target on the next cycle, and `illegal` stays 0.
- R5: A return request whose target is higher than the current level leaves the level unchanged. `illegal` is 1 for the following cycle.
- R6: When take and return requests arrive in the same cycle, only the take request is acted on. The return request is discarded and can neither move the level nor raise `illegal`.
- R7: `cur_el_view` holds the level in bits [3:2] and zero in every other bit. A write through `view_wr`/`view_wdata` changes neither the view nor any other output.
- R8: A configuration write (`cfg_wr`=1) made while the level is EL3 loads bit 0 of `cfg_wdata` into the non-secure bit (0 = Secure, 1 = Non-secure).
- R9: A configuration write made while the level is below EL3 leaves the non-secure bit unchanged and sets `illegal` to 1 on the next cycle.
- R10: `is_secure` is 1 whenever the level is EL3. At any other level it is the inverse of the non-secure bit.
- R11: A configuration write is judged against the level held before any take or return in the same cycle, so a write presented in the same cycle as an entry to EL3 is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Exception entry request |
| take_lvl | input | 2 | Target level of the entry |
| ret_req | input | 1 | Exception return request |
| ret_lvl | input | 2 | Target level of the return |
| cfg_wr | input | 1 | Secure configuration register write strobe |
| cfg_wdata | input | 64 | Write data; bit 0 is the non-secure bit |
| view_wr | input | 1 | Attempted software write to the level view |
| view_wdata | input | 64 | Data of that attempted write (discarded) |
| cur_el | output | 2 | Current level |
| cur_el_view | output | 64 | Read-only level view, level in bits [3:2] |
| is_secure | output | 1 | 1 when the current level runs in Secure state |
| illegal | output | 1 | Pulses when a request is refused |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a take and a return. The bench presents both requests together: a legal entry with a return that points down, and then an illegal entry with an illegal return. It confirms that the level follows the take alone and that `illegal` reflects only the take. The second pair is a configuration write together with a level change. The bench issues a write from EL0 in the same cycle as an entry to EL3, expects the write to be refused, and afterwards reads the untouched non-secure bit through `is_secure` once the level is back at EL1.

// File: rtl/el_pkg.sv
package el_pkg;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned REG_W = 64;
  localparam int unsigned VIEW_LSB = 2;
  localparam logic [LVL_W-1:0] EL_TOP = 2'd3;
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic [REG_W-1:0] pack_view(input lvl_t l);
    logic [REG_W-1:0] v;
    v = '0;
    v[VIEW_LSB +: LVL_W] = l;
    return v;
  endfunction
endpackage

// File: rtl/el_level_reg.sv
module el_level_reg
  import el_pkg::*;
#(
  parameter int unsigned HIGHEST_EL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic take_req,
  input  lvl_t take_lvl,
  input  logic ret_req,
  input  lvl_t ret_lvl,
  output lvl_t lvl_q,
  output lvl_t lvl_nxt,
  output logic fault_nxt
);
  localparam lvl_t RST_LVL = lvl_t'(HIGHEST_EL);

  always_comb begin
    lvl_nxt   = lvl_q;
    fault_nxt = 1'b0;
    if (take_req) begin
      // entry wins over a same-cycle return (R6)
      if (take_lvl >= lvl_q) lvl_nxt = take_lvl;
      else                   fault_nxt = 1'b1;
    end else if (ret_req) begin
      if (ret_lvl <= lvl_q) lvl_nxt = ret_lvl;
      else                  fault_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_LVL;
    else     lvl_q <= lvl_nxt;
  end

  p_reset_level_r1: assert property (@(posedge clk) rst |=> (lvl_q == RST_LVL));
  p_take_no_lower_r3: assert property (@(posedge clk) disable iff (rst)
    (take_req && take_lvl < lvl_q) |=> (lvl_q == $past(lvl_q)));
  p_take_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (take_req && take_lvl >= lvl_q) |=> (lvl_q == $past(take_lvl)));
  p_ret_no_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (!take_req && ret_req && ret_lvl > lvl_q) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/el_secure_cfg.sv
module el_secure_cfg
  import el_pkg::*;
#(
  parameter int unsigned NS_POS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  lvl_t             lvl_now,
  output logic             ns_q,
  output logic             ns_nxt,
  output logic             fault_nxt
);
  logic at_top;
  logic unused_cfg;

  assign at_top = (lvl_now == EL_TOP);
  assign unused_cfg = ^cfg_wdata;

  always_comb begin
    ns_nxt    = ns_q;
    fault_nxt = 1'b0;
    if (cfg_wr) begin
      if (at_top) ns_nxt    = cfg_wdata[NS_POS];
      else        fault_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ns_q <= 1'b0;
    else     ns_q <= ns_nxt;
  end

  p_cfg_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && lvl_now != EL_TOP) |=> (ns_q == $past(ns_q)));
  p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && lvl_now == EL_TOP) |=> (ns_q == $past(cfg_wdata[NS_POS])));
endmodule

// File: rtl/el_sec_tracker.sv
module el_sec_tracker
  import el_pkg::*;
#(
  parameter int unsigned HIGHEST_EL = 3,
  parameter int unsigned NS_POS     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_req,
  input  logic [1:0]       take_lvl,
  input  logic             ret_req,
  input  logic [1:0]       ret_lvl,
  input  logic             cfg_wr,
  input  logic [63:0]      cfg_wdata,
  input  logic             view_wr,
  input  logic [63:0]      view_wdata,
  output logic [1:0]       cur_el,
  output logic [63:0]      cur_el_view,
  output logic             is_secure,
  output logic             illegal
);
  lvl_t lvl_q, lvl_nxt;
  logic lvl_fault, ns_q, ns_nxt, cfg_fault;
  logic unused_view;

  // the view is read-only: an attempted write is absorbed here (R7)
  assign unused_view = view_wr ^ (^view_wdata) ^ ns_q;

  el_level_reg #(.HIGHEST_EL(HIGHEST_EL)) u_lvl (
    .clk(clk), .rst(rst),
    .take_req(take_req), .take_lvl(take_lvl),
    .ret_req(ret_req), .ret_lvl(ret_lvl),
    .lvl_q(lvl_q), .lvl_nxt(lvl_nxt), .fault_nxt(lvl_fault)
  );

  el_secure_cfg #(.NS_POS(NS_POS)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lvl_now(lvl_q),
    .ns_q(ns_q), .ns_nxt(ns_nxt), .fault_nxt(cfg_fault)
  );

  assign cur_el = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_el_view <= pack_view(lvl_t'(HIGHEST_EL));
      is_secure   <= (lvl_t'(HIGHEST_EL) == EL_TOP) ? 1'b1 : 1'b1;
      illegal     <= 1'b0;
    end else begin
      cur_el_view <= pack_view(lvl_nxt);
      is_secure   <= (lvl_nxt == EL_TOP) ? 1'b1 : ~ns_nxt;
      illegal     <= lvl_fault | cfg_fault;
    end
  end

  p_el3_secure_r10: assert property (@(posedge clk) disable iff (rst)
    (cur_el == EL_TOP) |-> is_secure);
  p_view_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    cur_el_view == pack_view(cur_el));
  p_fault_reported_r3: assert property (@(posedge clk) disable iff (rst)
    lvl_fault |=> illegal);
endmodule

// File: tb/tb_el_sec_tracker.sv
module tb_el_sec_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic take_req = 0, ret_req = 0, cfg_wr = 0, view_wr = 0;
  logic [1:0] take_lvl = 0, ret_lvl = 0;
  logic [63:0] cfg_wdata = 0, view_wdata = 0;
  logic [1:0] cur_el;
  logic [63:0] cur_el_view;
  logic is_secure, illegal;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  el_sec_tracker dut (
    .clk(clk), .rst(rst), .take_req(take_req), .take_lvl(take_lvl),
    .ret_req(ret_req), .ret_lvl(ret_lvl), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .view_wr(view_wr), .view_wdata(view_wdata), .cur_el(cur_el),
    .cur_el_view(cur_el_view), .is_secure(is_secure), .illegal(illegal)
  );

  // row: take,tlvl,ret,rlvl,cfg,nsbit,vwr | exp_el,exp_sec,exp_ill
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_00_0_00_1_1_0_11_1_0, // R8 R10: NS=1 written at EL3, still secure
    13'b0_00_1_01_0_0_0_01_0_0, // R4 R10: return to EL1, non-secure
    13'b1_00_0_00_0_0_0_01_0_1, // R3: take to lower level refused
    13'b0_00_0_00_1_0_0_01_0_1, // R9: cfg write from EL1 refused
    13'b1_01_0_00_0_0_0_01_0_0, // R2: take to equal level
    13'b0_00_1_10_0_0_0_01_0_1, // R5: return upward refused
    13'b1_10_0_00_0_0_0_10_0_0, // R2 R10: take to EL2
    13'b0_00_0_00_0_0_1_10_0_0, // R7: view write ignored
    13'b1_11_1_00_0_0_0_11_1_0, // R6: take wins over return
    13'b0_00_1_00_0_0_0_00_0_0, // R4: return to EL0
    13'b0_00_1_00_0_0_0_00_0_0, // R4: return to equal level
    13'b1_11_0_00_1_0_0_11_1_1, // R11: cfg refused despite entry to EL3
    13'b0_00_1_01_0_0_0_01_0_0, // R11: NS still 1 at EL1
    13'b1_00_1_11_0_0_0_01_0_1  // R6: illegal take, return dropped
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    take_req = 0; ret_req = 0; cfg_wr = 0; view_wr = 0;
  endtask

  initial begin : watchdog
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 el", 64'(cur_el), 64'd3);
    check("R1 view", cur_el_view, 64'hC);
    check("R1 sec", 64'(is_secure), 64'd1);
    check("R1 ill", 64'(illegal), 64'd0);
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      take_req = v[12]; take_lvl = v[11:10];
      ret_req = v[9]; ret_lvl = v[8:7];
      cfg_wr = v[6]; cfg_wdata = {63'h7FFF_FFFF_FFFF_FFFF & 63'h2A, v[5]};
      view_wr = v[4]; view_wdata = 64'hFFFF_FFFF_FFFF_FFF0;
      @(negedge clk);
      idle();
      check($sformatf("R2-vector %0d el", i), 64'(cur_el), 64'(v[3:2]));
      check($sformatf("R10 vector %0d sec", i), 64'(is_secure), 64'(v[1]));
      check($sformatf("R3 vector %0d ill", i), 64'(illegal), 64'(v[0]));
      check($sformatf("R7 vector %0d view", i), cur_el_view, {60'd0, v[3:2], 2'b00});
    end
    // R3: pulse lasts one cycle
    @(negedge clk);
    check("R3 pulse ends", 64'(illegal), 64'd0);
    check("R3 level kept", 64'(cur_el), 64'd1);
    // R1: reset mid-run restores top level and Secure lower levels
    rst = 1; @(negedge clk); rst = 0;
    check("R1 rerst el", 64'(cur_el), 64'd3);
    ret_req = 1; ret_lvl = 2'd0; @(negedge clk); idle();
    check("R1 ns cleared", 64'(is_secure), 64'd1);
    check("R4 el0", 64'(cur_el), 64'd0);
    // R7: view write at EL0 leaves everything alone
    view_wr = 1; view_wdata = '1; @(negedge clk); idle();
    check("R7 view", cur_el_view, 64'd0);
    check("R7 el", 64'(cur_el), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule